// File: doc/BRIEF.md
# Page Request Queue Writer

This block takes page requests from devices, one at a time, and appends each one as a 128-bit descriptor to a circular queue in system memory. Software owns the queue. It programs a base address and a size code, moves the head offset as it consumes entries, and reads the tail offset, which the block advances after each successful write. Before a request is queued, the block screens it for capability, PASID presence, flag consistency and the page-request-enable bit of the device's context. It also checks the queue for overflow before writing. Every request gets one completion code.

Two sticky status bits tell software what has happened: "pending" (new entries are waiting) and "overflow" (a request was lost because the queue was full). On the transition into either condition, the block raises a page-request event. The event becomes an interrupt message built from programmable address and data registers, unless it is masked. If it is masked, an interrupt-pending bit records it, and the message is sent later when software unmasks.

Context lookup is outside the block. The page-request-enable bit arrives with each request on its own input.

Top module: `prq_writer`

## Requirements
- R1: After reset the block is idle (`req_busy` 0), the status register reads 0, the tail register reads 0, the event control register reads 0x8000_0000 (mask set, interrupt-pending clear), and no interrupt message is sent.
- R2: An accepted request produces one memory write of 128 bits to base + tail. The write stays requested with a stable address until `mem_ack`. Low word: bits 7:0 = 0x01, bit 8 = PASID present, bits 31:16 = requester ID, bits 51:32 = PASID, bit 52 = privileged. High word: bit 0 = read, bit 1 = write, bit 2 = last in group, bits 11:3 = group index, bits 63:12 = page number.
- R3: After a successful write the tail becomes (tail + 16) mod 2^(size+11) bytes, where size is bits 2:0 of the queue address register (select 0, base in bits 63:12). This makes a queue of 2^(size+7) entries of 16 bytes.
- R4: A request is refused with code 1 (permission) and no memory write when the capability input is low or no PASID is present. A request with execute set and read clear gets code 2 (invalid).
- R5: A request whose page-request-enable input is low gets code 1 and a one-cycle fault pulse with reason 0x47 and the requester ID.
- R6: When the next tail equals the head, the request is dropped with code 3 (no space) and no write. The overflow status bit (bit 1) is set and an event is attempted.
- R7: While the overflow bit is set, every request that passes the screening checks is dropped with code 3: no write, no fault, no event, and status and tail are unchanged.
- R8: After a successful write, if the pending bit (status bit 0) is clear it is set and an event is attempted. If it is already set, no event occurs. The request then completes with code 0.
- R9: An attempted event is suppressed if the overflow or pending bit was set beforehand. Otherwise, with the mask (event control bit 31) clear, an interrupt message carrying the event address (select 5) and data (select 6) is sent and interrupt-pending (bit 30) stays clear. With the mask set, interrupt-pending is set and no message is sent.
- R10: A software write that clears the mask while interrupt-pending is set sends the deferred message and clears interrupt-pending.
- R11: A write that returns `mem_err` completes with code 4 (I/O error) and leaves tail and status unchanged.
- R12: Status bits are write-one-to-clear at select 3. Head (select 1) and tail (select 2) are byte offsets written by software.
- R13: `req_busy` is high from the cycle after a request is accepted for writing until its completion, and a memory write is only requested while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_rid | input | 16 | Requester ID |
| req_pasid_vld | input | 1 | PASID present |
| req_pasid | input | 20 | PASID |
| req_priv | input | 1 | Privileged-mode request |
| req_exec | input | 1 | Execute requested |
| req_read | input | 1 | Read requested |
| req_write | input | 1 | Write requested |
| req_last | input | 1 | Last request of the group |
| req_grp | input | 9 | Page request group index |
| req_page | input | 52 | Page number (address bits 63:12) |
| req_pre_en | input | 1 | Page-request-enable bit from the device context |
| cap_prs | input | 1 | Page request capability enabled |
| req_busy | output | 1 | Request in progress |
| cpl_valid | output | 1 | Completion pulse |
| cpl_code | output | 3 | 0 ok, 1 permission, 2 invalid, 3 no space, 4 I/O error |
| flt_valid | output | 1 | Fault record pulse |
| flt_reason | output | 8 | Fault reason |
| flt_rid | output | 16 | Requester ID of the fault |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 128 | Descriptor, high word in bits 127:64 |
| mem_ack | input | 1 | Memory write done |
| mem_err | input | 1 | Memory write failed, valid with `mem_ack` |
| irq_valid | output | 1 | Interrupt message pulse |
| irq_addr | output | 64 | Interrupt message address |
| irq_data | output | 32 | Interrupt message data |

## Verification
Results of a rejected or dropped request (completion code, fault pulse, the overflow bit and an interrupt message from an overflow event) appear in the cycle after the accepting edge. An accepted request shows `mem_req` one cycle after acceptance. With a same-cycle acknowledge, the tail moves one cycle later, and the completion, the pending bit and any interrupt arrive one cycle after that. A deferred interrupt appears in the cycle after the unmasking register write. The bench drives inputs on falling edges and samples on falling edges. It waits a fixed four falling edges after each request, which covers the longest of these paths, and only then compares against counters and captured values.

// File: rtl/prq_pkg.sv
package prq_pkg;
  localparam int RID_W   = 16;
  localparam int PASID_W = 20;
  localparam int GRP_W   = 9;
  localparam int PAGE_W  = 52;
  localparam int DESC_W  = 128;
  localparam int ENTRY_BYTES = 16;
  localparam int QSIZE_BASE  = 11; // log2 of (128 entries * 16 bytes)
  localparam logic [7:0] DESC_KIND = 8'h01;
  localparam logic [7:0] FLT_PRE_OFF = 8'h47;

  typedef enum logic [2:0] {
    CPL_OK    = 3'd0,
    CPL_PERM  = 3'd1,
    CPL_INVAL = 3'd2,
    CPL_NOSPC = 3'd3,
    CPL_IO    = 3'd4
  } cpl_e;

  typedef enum logic [2:0] {
    RS_QADDR = 3'd0,
    RS_HEAD  = 3'd1,
    RS_TAIL  = 3'd2,
    RS_STAT  = 3'd3,
    RS_EVCTL = 3'd4,
    RS_EVADR = 3'd5,
    RS_EVDAT = 3'd6
  } rsel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_STAT = 2'd2
  } wst_e;

  typedef struct packed {
    logic [PAGE_W-1:0]  page;
    logic [GRP_W-1:0]   grp;
    logic               last;
    logic               wr;
    logic               rd;
    logic [10:0]        rsv_b;
    logic               priv;
    logic [PASID_W-1:0] pasid;
    logic [RID_W-1:0]   rid;
    logic [6:0]         rsv_a;
    logic               pp;
    logic [7:0]         kind;
  } desc_t;
endpackage

// File: rtl/prq_desc_fmt.sv
module prq_desc_fmt
  import prq_pkg::*;
(
  input  logic [RID_W-1:0]   rid,
  input  logic               pasid_vld,
  input  logic [PASID_W-1:0] pasid,
  input  logic               priv,
  input  logic               rd,
  input  logic               wr,
  input  logic               last,
  input  logic [GRP_W-1:0]   grp,
  input  logic [PAGE_W-1:0]  page,
  output logic [DESC_W-1:0]  desc
);
  desc_t d;

  always_comb begin
    d       = '0;
    d.kind  = DESC_KIND;
    d.pp    = pasid_vld;
    d.rid   = rid;
    d.pasid = pasid;
    d.priv  = priv;
    d.rd    = rd;
    d.wr    = wr;
    d.last  = last;
    d.grp   = grp;
    d.page  = page;
    desc    = d;
  end
endmodule

// File: rtl/prq_regs.sv
module prq_regs
  import prq_pkg::*;
#(
  parameter int SIZE_W = 3,
  localparam int OFF_W = (1 << SIZE_W) - 1 + QSIZE_BASE
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [63:0]      reg_wdata,
  input  logic             hw_tail_we,
  input  logic [OFF_W-1:0] hw_tail,
  input  logic             hw_set_pro,
  input  logic             hw_set_ppr,
  output logic [51:0]      q_base,
  output logic [SIZE_W-1:0] q_size,
  output logic [OFF_W-1:0] head,
  output logic [OFF_W-1:0] tail,
  output logic             st_ppr,
  output logic             st_pro,
  output logic [63:0]      ev_addr,
  output logic [31:0]      ev_data
);
  logic wr_q, wr_h, wr_t, wr_s, wr_a, wr_d;
  logic [OFF_W-1:0] tail_n;
  logic ppr_n, pro_n;

  always_comb begin
    wr_q = reg_we && (reg_sel == RS_QADDR);
    wr_h = reg_we && (reg_sel == RS_HEAD);
    wr_t = reg_we && (reg_sel == RS_TAIL);
    wr_s = reg_we && (reg_sel == RS_STAT);
    wr_a = reg_we && (reg_sel == RS_EVADR);
    wr_d = reg_we && (reg_sel == RS_EVDAT);
    tail_n = tail;
    if (wr_t)       tail_n = {reg_wdata[OFF_W-1:4], 4'b0};
    if (hw_tail_we) tail_n = hw_tail;
    ppr_n = (st_ppr & ~(wr_s & reg_wdata[0])) | hw_set_ppr;
    pro_n = (st_pro & ~(wr_s & reg_wdata[1])) | hw_set_pro;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_base <= '0;
      q_size <= '0;
    end else if (wr_q) begin
      q_base <= reg_wdata[63:12];
      q_size <= reg_wdata[SIZE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     head <= '0;
    else if (wr_h)  head <= {reg_wdata[OFF_W-1:4], 4'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tail <= '0;
    else if (wr_t || hw_tail_we)  tail <= tail_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ppr <= 1'b0;
      st_pro <= 1'b0;
    end else begin
      st_ppr <= ppr_n;
      st_pro <= pro_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ev_addr <= '0;
    else if (wr_a) ev_addr <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ev_data <= '0;
    else if (wr_d) ev_data <= reg_wdata[31:0];
  end
endmodule

// File: rtl/prq_event.sv
module prq_event (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_try,
  input  logic        old_pro,
  input  logic        old_ppr,
  input  logic        sw_we,
  input  logic        sw_mask,
  input  logic [63:0] ev_addr,
  input  logic [31:0] ev_data,
  output logic        mask,
  output logic        ip,
  output logic        irq_valid,
  output logic [63:0] irq_addr,
  output logic [31:0] irq_data
);
  logic fire, send, mask_n, ip_n;

  always_comb begin
    fire   = ev_try && !old_pro && !old_ppr;
    mask_n = sw_we ? sw_mask : mask;
    ip_n   = ip;
    send   = 1'b0;
    if (fire) begin
      if (mask) ip_n = 1'b1;
      else      send = 1'b1;
    end
    if (sw_we && !sw_mask && ip_n) begin
      ip_n = 1'b0;
      send = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= 1'b1;
      ip        <= 1'b0;
      irq_valid <= 1'b0;
    end else begin
      mask      <= mask_n;
      ip        <= ip_n;
      irq_valid <= send;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_addr <= '0;
      irq_data <= '0;
    end else if (send) begin
      irq_addr <= ev_addr;
      irq_data <= ev_data;
    end
  end
endmodule

// File: rtl/prq_ctrl.sv
module prq_ctrl
  import prq_pkg::*;
#(
  parameter int SIZE_W = 3,
  localparam int OFF_W = (1 << SIZE_W) - 1 + QSIZE_BASE
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [RID_W-1:0]   req_rid,
  input  logic               req_pasid_vld,
  input  logic               req_exec,
  input  logic               req_read,
  input  logic               req_pre_en,
  input  logic               cap_prs,
  input  logic [DESC_W-1:0]  desc,
  input  logic [51:0]        q_base,
  input  logic [SIZE_W-1:0]  q_size,
  input  logic [OFF_W-1:0]   head,
  input  logic [OFF_W-1:0]   tail,
  input  logic               st_ppr,
  input  logic               st_pro,
  input  logic               mem_ack,
  input  logic               mem_err,
  output logic               busy,
  output logic               mem_req,
  output logic [63:0]        mem_addr,
  output logic [DESC_W-1:0]  mem_data,
  output logic               tail_we,
  output logic [OFF_W-1:0]   tail_new,
  output logic               set_pro,
  output logic               set_ppr,
  output logic               ev_try,
  output logic               ev_pro,
  output logic               ev_ppr,
  output logic               cpl_valid,
  output logic [2:0]         cpl_code,
  output logic               flt_valid,
  output logic [7:0]         flt_reason,
  output logic [RID_W-1:0]   flt_rid
);
  wst_e state, state_n;
  logic [OFF_W-1:0] wrap_mask, nxt_tail, tnew_n;
  logic [63:0] addr_n;
  logic [DESC_W-1:0] data_n;
  logic cplv_n, fltv_n, cap_en;
  logic [2:0] code_n;

  always_comb begin
    wrap_mask = (OFF_W'(1) << (32'(q_size) + QSIZE_BASE)) - OFF_W'(1);
    nxt_tail  = (tail + OFF_W'(ENTRY_BYTES)) & wrap_mask;
  end

  always_comb begin
    state_n = state;
    cplv_n  = 1'b0;
    code_n  = cpl_code;
    fltv_n  = 1'b0;
    addr_n  = mem_addr;
    data_n  = mem_data;
    tnew_n  = tail_new;
    cap_en  = 1'b0;
    tail_we = 1'b0;
    set_pro = 1'b0;
    set_ppr = 1'b0;
    ev_try  = 1'b0;
    ev_pro  = st_pro;
    ev_ppr  = st_ppr;
    case (state)
      ST_IDLE: if (req_valid) begin
        cplv_n = 1'b1;
        if (!cap_prs || !req_pasid_vld) begin
          code_n = CPL_PERM;
        end else if (req_exec && !req_read) begin
          code_n = CPL_INVAL;
        end else if (!req_pre_en) begin
          code_n = CPL_PERM;
          fltv_n = 1'b1;
        end else if (st_pro) begin
          code_n = CPL_NOSPC;
        end else if (nxt_tail == head) begin
          code_n  = CPL_NOSPC;
          set_pro = 1'b1;
          ev_try  = 1'b1;
        end else begin
          cplv_n  = 1'b0;
          cap_en  = 1'b1;
          state_n = ST_WR;
          addr_n  = {q_base, 12'b0} + 64'(tail);
          data_n  = desc;
          tnew_n  = nxt_tail;
        end
      end
      ST_WR: if (mem_ack) begin
        if (mem_err) begin
          cplv_n  = 1'b1;
          code_n  = CPL_IO;
          state_n = ST_IDLE;
        end else begin
          tail_we = 1'b1;
          state_n = ST_STAT;
        end
      end
      ST_STAT: begin
        cplv_n  = 1'b1;
        code_n  = CPL_OK;
        state_n = ST_IDLE;
        if (!st_ppr) begin
          set_ppr = 1'b1;
          ev_try  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cpl_valid <= 1'b0;
      cpl_code  <= CPL_OK;
      flt_valid <= 1'b0;
    end else begin
      state     <= state_n;
      cpl_valid <= cplv_n;
      cpl_code  <= code_n;
      flt_valid <= fltv_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_data <= '0;
      tail_new <= '0;
    end else if (cap_en) begin
      mem_addr <= addr_n;
      mem_data <= data_n;
      tail_new <= tnew_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_rid    <= '0;
      flt_reason <= '0;
    end else if (fltv_n) begin
      flt_rid    <= req_rid;
      flt_reason <= FLT_PRE_OFF;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign mem_req = (state == ST_WR);
endmodule

// File: rtl/prq_writer.sv
module prq_writer
  import prq_pkg::*;
#(
  parameter int SIZE_W = 3,
  localparam int OFF_W = (1 << SIZE_W) - 1 + QSIZE_BASE
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [15:0]  req_rid,
  input  logic         req_pasid_vld,
  input  logic [19:0]  req_pasid,
  input  logic         req_priv,
  input  logic         req_exec,
  input  logic         req_read,
  input  logic         req_write,
  input  logic         req_last,
  input  logic [8:0]   req_grp,
  input  logic [51:0]  req_page,
  input  logic         req_pre_en,
  input  logic         cap_prs,
  output logic         req_busy,
  output logic         cpl_valid,
  output logic [2:0]   cpl_code,
  output logic         flt_valid,
  output logic [7:0]   flt_reason,
  output logic [15:0]  flt_rid,
  input  logic         reg_we,
  input  logic [2:0]   reg_sel,
  input  logic [63:0]  reg_wdata,
  output logic [63:0]  reg_rdata,
  output logic         mem_req,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  input  logic         mem_ack,
  input  logic         mem_err,
  output logic         irq_valid,
  output logic [63:0]  irq_addr,
  output logic [31:0]  irq_data
);
  logic [DESC_W-1:0] desc;
  logic [51:0]       q_base;
  logic [SIZE_W-1:0] q_size;
  logic [OFF_W-1:0]  head, tail, tail_new;
  logic              st_ppr, st_pro, tail_we, set_pro, set_ppr;
  logic              ev_try, ev_pro, ev_ppr, ev_mask, ev_ip;
  logic [63:0]       ev_addr;
  logic [31:0]       ev_data;

  prq_desc_fmt u_fmt (
    .rid(req_rid), .pasid_vld(req_pasid_vld), .pasid(req_pasid),
    .priv(req_priv), .rd(req_read), .wr(req_write), .last(req_last),
    .grp(req_grp), .page(req_page), .desc(desc)
  );

  prq_regs #(.SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .hw_tail_we(tail_we), .hw_tail(tail_new),
    .hw_set_pro(set_pro), .hw_set_ppr(set_ppr), .q_base(q_base),
    .q_size(q_size), .head(head), .tail(tail), .st_ppr(st_ppr),
    .st_pro(st_pro), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  prq_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rid(req_rid),
    .req_pasid_vld(req_pasid_vld), .req_exec(req_exec),
    .req_read(req_read), .req_pre_en(req_pre_en), .cap_prs(cap_prs),
    .desc(desc), .q_base(q_base), .q_size(q_size), .head(head),
    .tail(tail), .st_ppr(st_ppr), .st_pro(st_pro), .mem_ack(mem_ack),
    .mem_err(mem_err), .busy(req_busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .tail_we(tail_we),
    .tail_new(tail_new), .set_pro(set_pro), .set_ppr(set_ppr),
    .ev_try(ev_try), .ev_pro(ev_pro), .ev_ppr(ev_ppr),
    .cpl_valid(cpl_valid), .cpl_code(cpl_code), .flt_valid(flt_valid),
    .flt_reason(flt_reason), .flt_rid(flt_rid)
  );

  prq_event u_event (
    .clk(clk), .rst_n(rst_n), .ev_try(ev_try), .old_pro(ev_pro),
    .old_ppr(ev_ppr), .sw_we(reg_we && (reg_sel == RS_EVCTL)),
    .sw_mask(reg_wdata[31]), .ev_addr(ev_addr), .ev_data(ev_data),
    .mask(ev_mask), .ip(ev_ip), .irq_valid(irq_valid),
    .irq_addr(irq_addr), .irq_data(irq_data)
  );

  always_comb begin
    case (reg_sel)
      RS_QADDR: reg_rdata = {q_base, {(12-SIZE_W){1'b0}}, q_size};
      RS_HEAD:  reg_rdata = 64'(head);
      RS_TAIL:  reg_rdata = 64'(tail);
      RS_STAT:  reg_rdata = {62'b0, st_pro, st_ppr};
      RS_EVCTL: reg_rdata = {32'b0, ev_mask, ev_ip, 30'b0};
      RS_EVADR: reg_rdata = ev_addr;
      RS_EVDAT: reg_rdata = {32'b0, ev_data};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/prq_writer_chk.sv
module prq_writer_chk #(
  parameter int OFF_W = 18
)(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [63:0]      mem_addr,
  input logic             cpl_valid,
  input logic [2:0]       cpl_code,
  input logic             flt_valid,
  input logic [OFF_W-1:0] tail,
  input logic             st_pro,
  input logic             reg_we,
  input logic [2:0]       reg_sel,
  input logic [63:0]      reg_wdata
);
  // R13
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> (cpl_valid && cpl_code == 3'd1));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pro && !(reg_we && reg_sel == 3'd3 && reg_wdata[1])) |=> st_pro);

  // R11
  no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && (cpl_code == 3'd3 || cpl_code == 3'd4) && !$past(reg_we))
      |-> $stable(tail));
endmodule

bind prq_writer prq_writer_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(req_busy), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .cpl_valid(cpl_valid),
  .cpl_code(cpl_code), .flt_valid(flt_valid), .tail(tail),
  .st_pro(st_pro), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata)
);

// File: tb/tb_prq_writer.sv
`timescale 1ns/1ps
module tb_prq_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_pasid_vld = 1, req_priv = 0, req_exec = 0;
  logic req_read = 1, req_write = 0, req_last = 0, req_pre_en = 1, cap_prs = 1;
  logic [15:0] req_rid = 16'h0100;
  logic [19:0] req_pasid = 20'h00007;
  logic [8:0]  req_grp = 9'd0;
  logic [51:0] req_page = 52'h1;
  logic req_busy, cpl_valid, flt_valid, mem_req, irq_valid;
  logic [2:0] cpl_code;
  logic [7:0] flt_reason;
  logic [15:0] flt_rid;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [63:0] reg_wdata = 0, reg_rdata, mem_addr, irq_addr;
  logic [127:0] mem_data;
  logic mem_ack = 0, mem_err = 0, err_mode = 0;
  logic [31:0] irq_data;

  int tests = 0, fails = 0;
  int wr_cnt = 0, irq_cnt = 0, flt_cnt = 0, cpl_cnt = 0;
  logic [63:0] last_addr, last_iaddr;
  logic [127:0] last_data;
  logic [31:0] last_idata;
  logic [2:0] last_code;
  logic [7:0] last_reason;
  logic [15:0] last_frid;
  bit done = 0;

  localparam logic [63:0] QBASE = 64'h0000_0000_1234_5000;

  prq_writer dut (.*);

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1; mem_err = err_mode;
      wr_cnt++; last_addr = mem_addr; last_data = mem_data;
    end else begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end
    if (irq_valid) begin irq_cnt++; last_iaddr = irq_addr; last_idata = irq_data; end
    if (flt_valid) begin flt_cnt++; last_reason = flt_reason; last_frid = flt_rid; end
    if (cpl_valid) begin cpl_cnt++; last_code = cpl_code; end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] s, logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(logic [2:0] s, output logic [63:0] v);
    @(negedge clk); reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic go();
    @(negedge clk); req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    #1;
  endtask

  typedef struct packed {
    logic cap, pp, ex, rd, wr, pre;
    logic [2:0] code;
    logic wrote, flt;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1}
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int w0, i0, f0, c0;
    logic [127:0] exp_d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 busy", 128'(req_busy), 0);
    rd_reg(3'd3, v); chk("R1 status", v, 0);
    rd_reg(3'd2, v); chk("R1 tail", v, 0);
    rd_reg(3'd4, v); chk("R1 evctl", v, 64'h8000_0000);
    chk("R1 no irq", 128'(irq_cnt), 0);

    wr_reg(3'd0, QBASE);
    wr_reg(3'd1, 64'h400);
    wr_reg(3'd5, 64'hFEE0_0000);
    wr_reg(3'd6, 64'h41);
    wr_reg(3'd4, 64'h0);

    // R2 R4 R5 table of screening cases
    for (int k = 0; k < 6; k++) begin
      cap_prs = VEC[k].cap; req_pasid_vld = VEC[k].pp; req_exec = VEC[k].ex;
      req_read = VEC[k].rd; req_write = VEC[k].wr; req_pre_en = VEC[k].pre;
      req_rid = 16'h0A00 + 16'(k);
      w0 = wr_cnt; f0 = flt_cnt; c0 = cpl_cnt;
      go();
      chk($sformatf("R4 vec%0d code", k), 128'(last_code), 128'(VEC[k].code));
      chk($sformatf("R4 vec%0d cpl", k), 128'(cpl_cnt - c0), 1);
      chk($sformatf("R2 vec%0d write", k), 128'(wr_cnt - w0), 128'(VEC[k].wrote));
      chk($sformatf("R5 vec%0d fault", k), 128'(flt_cnt - f0), 128'(VEC[k].flt));
      if (VEC[k].flt) begin
        chk("R5 reason", 128'(last_reason), 128'h47);
        chk("R5 rid", 128'(last_frid), 128'(16'h0A05));
      end
    end
    cap_prs = 1; req_pasid_vld = 1; req_exec = 0; req_pre_en = 1;
    rd_reg(3'd2, v); chk("R3 tail after two", v, 64'h20);

    // R2 R8 R9 descriptor layout and first event
    wr_reg(3'd3, 64'h3);
    req_rid = 16'h0A13; req_pasid = 20'h5A5A5; req_priv = 1; req_read = 1;
    req_write = 0; req_last = 1; req_grp = 9'h1C3; req_page = 52'hABCDE;
    i0 = irq_cnt;
    go();
    exp_d[63:0] = 64'h01 | (64'h1 << 8) | (64'h0A13 << 16) | (64'h5A5A5 << 32) | (64'h1 << 52);
    exp_d[127:64] = 64'h1 | (64'h1 << 2) | (64'h1C3 << 3) | (64'hABCDE << 12);
    chk("R2 addr", last_addr, QBASE + 64'h20);
    chk("R2 data", last_data, exp_d);
    chk("R8 code ok", 128'(last_code), 0);
    rd_reg(3'd3, v); chk("R8 pending set", v, 1);
    chk("R9 irq sent", 128'(irq_cnt - i0), 1);
    chk("R9 irq addr", last_iaddr, 64'hFEE0_0000);
    chk("R9 irq data", 128'(last_idata), 128'h41);
    rd_reg(3'd4, v); chk("R9 ip clear", v, 0);

    // R8 pending already set -> no event
    req_priv = 0; req_last = 0;
    i0 = irq_cnt; go();
    chk("R8 no second irq", 128'(irq_cnt - i0), 0);
    rd_reg(3'd2, v); chk("R3 tail 0x40", v, 64'h40);

    // R12 write-one-to-clear
    wr_reg(3'd3, 64'h1);
    rd_reg(3'd3, v); chk("R12 w1c", v, 0);

    // R9 masked, R10 deferred
    wr_reg(3'd4, 64'h8000_0000);
    i0 = irq_cnt; go();
    chk("R9 masked no irq", 128'(irq_cnt - i0), 0);
    rd_reg(3'd4, v); chk("R9 ip set", v, 64'hC000_0000);
    wr_reg(3'd4, 64'h0);
    @(negedge clk); #1;
    chk("R10 deferred irq", 128'(irq_cnt - i0), 1);
    rd_reg(3'd4, v); chk("R10 ip cleared", v, 0);
    wr_reg(3'd3, 64'h3);

    // R11 memory error
    err_mode = 1; go(); err_mode = 0;
    chk("R11 code io", 128'(last_code), 4);
    rd_reg(3'd2, v); chk("R11 tail kept", v, 64'h50);
    rd_reg(3'd3, v); chk("R11 status kept", v, 0);

    // R3 wrap at end of 128-entry queue
    wr_reg(3'd2, 64'h7F0); wr_reg(3'd1, 64'h100); wr_reg(3'd3, 64'h3);
    go();
    chk("R3 wrap addr", last_addr, QBASE + 64'h7F0);
    rd_reg(3'd2, v); chk("R3 wrap tail", v, 0);

    // R6 full queue
    wr_reg(3'd2, 64'h7F0); wr_reg(3'd1, 64'h0); wr_reg(3'd3, 64'h3);
    w0 = wr_cnt; i0 = irq_cnt;
    go();
    chk("R6 code nospc", 128'(last_code), 3);
    chk("R6 no write", 128'(wr_cnt - w0), 0);
    rd_reg(3'd3, v); chk("R6 overflow set", v, 2);
    chk("R6 event irq", 128'(irq_cnt - i0), 1);

    // R7 overflow sticky drop
    w0 = wr_cnt; i0 = irq_cnt; f0 = flt_cnt;
    go();
    chk("R7 code nospc", 128'(last_code), 3);
    chk("R7 no write", 128'(wr_cnt - w0), 0);
    chk("R7 no irq", 128'(irq_cnt - i0), 0);
    chk("R7 no fault", 128'(flt_cnt - f0), 0);
    rd_reg(3'd3, v); chk("R7 status", v, 2);
    rd_reg(3'd2, v); chk("R7 tail", v, 64'h7F0);

    // R13 busy window
    wr_reg(3'd3, 64'h3); wr_reg(3'd1, 64'h400); wr_reg(3'd2, 64'h0);
    @(negedge clk); req_valid = 1;
    @(negedge clk); req_valid = 0; #1;
    chk("R13 busy", 128'(req_busy), 1);
    repeat (4) @(negedge clk); #1;
    chk("R13 idle again", 128'(req_busy), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule